// File: doc/BRIEF.md
# Set-Keep Muller C-Element

This block is a parameterised Muller C-element whose feedback lives in one clocked state bit. Each clock, the next output is formed from two functions of the sampled inputs that contain no feedback of their own. The SET function is one of them. The other is a KEEP function that says when the current output is allowed to persist. The output itself is the only term that feeds back. One structure therefore covers the plain n-input C-element, the 2-input majority form, and asymmetric elements whose set and reset conditions draw on different input groups, as latch controllers need.

A mode input picks between the two behaviours. In symmetric mode every request line takes part in both the set and the hold condition. In asymmetric mode three masks choose which lines must be high to set, which must be high to reset, and which must be low to reset. The composed SET/KEEP pair is also driven out combinationally. Upstream pair inputs let one element absorb another's pair, so elements can be chained in the set/keep algebra rather than through their registered outputs.

Top module: `setkeep_celem`

## Requirements
- R1: A synchronous active-high reset clears the output to 0 at the clock edge, whatever the other inputs are.
- R2: At every clock edge out of reset, the output takes SET | (current output & KEEP), where SET and KEEP are computed from the inputs sampled at that edge. The new value is visible just after the edge.
- R3: In symmetric mode the output becomes 1 once every request is 1. It holds its value while at least one request is 1, and it becomes 0 only when every request is 0.
- R4: For a 2-input instance in symmetric mode with requests a (bit 0) and b (bit 1), the next output equals ab + bc + ac, where c is the current output.
- R5: In asymmetric mode, SET is the AND of the request bits whose bit in the set-group mask is 1. A set-group mask of all zeros never sets.
- R6: In asymmetric mode, RESET is true when every request bit marked in the reset-high mask is 1 and every request bit marked in the reset-low mask is 0. KEEP is the complement of RESET. If both reset masks are zero, the element never resets.
- R7: A mode input of 0 selects symmetric mode and 1 selects asymmetric mode. In symmetric mode the three masks have no effect on the output.
- R8: The upstream set input is ANDed into SET and the upstream keep input is ORed into KEEP. The composed pair appears on the set and keep outputs in the same cycle as the inputs. Upstream values 1 (set) and 0 (keep) are neutral.
- R9: A 2-input instance on a1, a2 feeding its pair outputs into the upstream inputs of a 1-input instance on a3 gives, on that 1-input instance, the same output as a 3-input instance on {a3, a2, a1} at every clock.
- R10: With set mask on bits 1 and 2 and reset on bit 0 high with bit 1 low (set = bc, reset = ab'), SET and RESET are never true together. The output follows next = bc + c·(ab')' for every input pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 symmetric, 1 asymmetric |
| req_i | input | N | Request inputs |
| set_grp_i | input | N | Asymmetric: bits that must be 1 to set |
| rst_hi_i | input | N | Asymmetric: bits that must be 1 to reset |
| rst_lo_i | input | N | Asymmetric: bits that must be 0 to reset |
| up_set_i | input | 1 | Upstream SET term, ANDed in |
| up_keep_i | input | 1 | Upstream KEEP term, ORed in |
| c_o | output | 1 | Registered C-element output |
| set_o | output | 1 | Composed SET for the current inputs |
| keep_o | output | 1 | Composed KEEP for the current inputs |

## Verification
The bench targets the hold cases. A partial request pattern with the output high must keep it high, and the same pattern with the output low must keep it low. An element that treated a C-element as a plain AND or OR gate would drop or raise the output there. In asymmetric mode the bench drives empty set and empty reset groups; a design that took an empty product as true would set or clear spuriously. A random cascade run compares the chained pair against a 3-input element. If the chain were composed through registered outputs instead of SET/KEEP pairs, its output would lag by a cycle or drop early.

// File: rtl/ce_pkg.sv
`timescale 1ns/1ps
package ce_pkg;

    typedef enum logic {
        CE_SYM  = 1'b0,
        CE_ASYM = 1'b1
    } ce_mode_e;

    // Feedback-free pair: set term and keep term
    typedef struct packed {
        logic set;
        logic keep;
    } sk_pair_t;

    // Composition rule of two C-element pairs
    function automatic sk_pair_t sk_join(sk_pair_t a, sk_pair_t b);
        sk_pair_t r;
        r.set  = a.set & b.set;
        r.keep = a.keep | b.keep;
        return r;
    endfunction

    // Next state with the output as the only feedback
    function automatic logic sk_next(sk_pair_t p, logic f);
        return p.set | (f & p.keep);
    endfunction

endpackage

// File: rtl/ce_sym_fn.sv
`timescale 1ns/1ps
module ce_sym_fn #(
    parameter int N = 4
) (
    input  logic [N-1:0]     req,
    output ce_pkg::sk_pair_t fn
);
    import ce_pkg::*;

    // Fold one input at a time: a plain input is the pair {a, a}
    sk_pair_t chain [0:N];

    assign chain[0] = sk_pair_t'(2'b10);

    for (genvar i = 0; i < N; i++) begin : g_fold
        assign chain[i+1] = sk_join(chain[i], sk_pair_t'({req[i], req[i]}));
    end

    assign fn = chain[N];
endmodule

// File: rtl/ce_asym_fn.sv
`timescale 1ns/1ps
module ce_asym_fn #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] set_grp,
    input  logic [N-1:0] rst_hi,
    input  logic [N-1:0] rst_lo,
    output logic         set_hit,
    output logic         rst_hit
);
    logic [N-1:0] s_ok;
    logic [N-1:0] r_ok;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign s_ok[i] = ~set_grp[i] | req[i];
        assign r_ok[i] = (~rst_hi[i] | req[i]) & (~rst_lo[i] | ~req[i]);
    end

    // Empty groups never fire
    assign set_hit = (|set_grp) & (&s_ok);
    assign rst_hit = (|(rst_hi | rst_lo)) & (&r_ok);
endmodule

// File: rtl/ce_state.sv
`timescale 1ns/1ps
module ce_state (
    input  logic             clk,
    input  logic             rst,
    input  ce_pkg::sk_pair_t fn,
    output logic             q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= ce_pkg::sk_next(fn, q);
    end
endmodule

// File: rtl/setkeep_celem.sv
`timescale 1ns/1ps
module setkeep_celem #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_i,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] set_grp_i,
    input  logic [N-1:0] rst_hi_i,
    input  logic [N-1:0] rst_lo_i,
    input  logic         up_set_i,
    input  logic         up_keep_i,
    output logic         c_o,
    output logic         set_o,
    output logic         keep_o
);
    import ce_pkg::*;

    ce_mode_e mode;
    sk_pair_t sym_fn;
    sk_pair_t asym_fn;
    sk_pair_t local_fn;
    sk_pair_t up_fn;
    sk_pair_t full_fn;
    logic     asym_set;
    logic     asym_rst;

    assign mode = ce_mode_e'(mode_i);

    ce_sym_fn #(.N(N)) u_sym (
        .req (req_i),
        .fn  (sym_fn)
    );

    ce_asym_fn #(.N(N)) u_asym (
        .req     (req_i),
        .set_grp (set_grp_i),
        .rst_hi  (rst_hi_i),
        .rst_lo  (rst_lo_i),
        .set_hit (asym_set),
        .rst_hit (asym_rst)
    );

    assign asym_fn  = '{set: asym_set, keep: ~asym_rst};
    assign local_fn = (mode == CE_ASYM) ? asym_fn : sym_fn;
    assign up_fn    = '{set: up_set_i, keep: up_keep_i};
    assign full_fn  = sk_join(local_fn, up_fn);

    ce_state u_state (
        .clk (clk),
        .rst (rst),
        .fn  (full_fn),
        .q   (c_o)
    );

    assign set_o  = full_fn.set;
    assign keep_o = full_fn.keep;
endmodule

// File: rtl/ce_checker.sv
`timescale 1ns/1ps
module ce_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         mode_i,
    input logic [N-1:0] req_i,
    input logic [N-1:0] set_grp_i,
    input logic         up_set_i,
    input logic         up_keep_i,
    input logic         c_o,
    input logic         set_o,
    input logic         keep_o,
    input logic         asym_set,
    input logic         asym_rst
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !c_o);

    p_next_state_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (c_o == ($past(set_o) | ($past(c_o) & $past(keep_o)))));

    p_sym_set_r3: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && (&req_i) && up_set_i) |=> c_o);

    p_sym_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && !(|req_i) && !up_keep_i) |=> !c_o);

    p_empty_set_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_i && (set_grp_i == '0)) |-> !set_o);

    p_reset_drops_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_i && asym_rst && !up_keep_i) |-> !keep_o);

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
        mode_i |-> !(asym_set && asym_rst));
endmodule

bind setkeep_celem ce_checker #(.N(N)) u_ce_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .req_i     (req_i),
    .set_grp_i (set_grp_i),
    .up_set_i  (up_set_i),
    .up_keep_i (up_keep_i),
    .c_o       (c_o),
    .set_o     (set_o),
    .keep_o    (keep_o),
    .asym_set  (asym_set),
    .asym_rst  (asym_rst)
);

// File: tb/setkeep_celem_bench.sv
`timescale 1ns/1ps
module setkeep_celem_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // main 4-input instance
    logic [3:0] req4 = '0, sg4 = '0, rh4 = '0, rl4 = '0;
    logic       md4 = 1'b0, us4 = 1'b1, uk4 = 1'b0;
    logic       c4, s4, k4;
    logic       m4 = 1'b0;

    // cascade group
    logic [1:0] a12 = '0;
    logic       a3  = 1'b0;
    logic       c2, s2, k2, c1, s1, k1, c3, s3, k3;
    logic       mc2 = 1'b0, mc3 = 1'b0;

    setkeep_celem #(.N(4)) u_setkeep_celem (
        .clk(clk), .rst(rst), .mode_i(md4), .req_i(req4),
        .set_grp_i(sg4), .rst_hi_i(rh4), .rst_lo_i(rl4),
        .up_set_i(us4), .up_keep_i(uk4),
        .c_o(c4), .set_o(s4), .keep_o(k4));

    setkeep_celem #(.N(2)) u_c2 (
        .clk(clk), .rst(rst), .mode_i(1'b0), .req_i(a12),
        .set_grp_i(2'b0), .rst_hi_i(2'b0), .rst_lo_i(2'b0),
        .up_set_i(1'b1), .up_keep_i(1'b0),
        .c_o(c2), .set_o(s2), .keep_o(k2));

    setkeep_celem #(.N(1)) u_c1 (
        .clk(clk), .rst(rst), .mode_i(1'b0), .req_i(a3),
        .set_grp_i(1'b0), .rst_hi_i(1'b0), .rst_lo_i(1'b0),
        .up_set_i(s2), .up_keep_i(k2),
        .c_o(c1), .set_o(s1), .keep_o(k1));

    setkeep_celem #(.N(3)) u_c3 (
        .clk(clk), .rst(rst), .mode_i(1'b0), .req_i({a3, a12}),
        .set_grp_i(3'b0), .rst_hi_i(3'b0), .rst_lo_i(3'b0),
        .up_set_i(1'b1), .up_keep_i(1'b0),
        .c_o(c3), .set_o(s3), .keep_o(k3));

    task automatic chk(input string rq, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", rq, what, act, exp);
        end
    endtask

    // Reference SET/KEEP from the requirements: {set, keep}
    function automatic logic [1:0] ref_fn(input logic md, input logic [3:0] r, sg, rh, rl,
                                          input logic us, uk);
        logic s, k, rs;
        if (!md) begin
            s = (r == 4'hF);
            k = (r != 4'h0);
        end else begin
            s  = (sg != 4'h0) && ((r & sg) == sg);
            rs = ((rh | rl) != 4'h0) && ((r & rh) == rh) && ((~r & rl) == rl);
            k  = !rs;
        end
        return {s & us, k | uk};
    endfunction

    task automatic step4(input string tag, input logic md, input logic [3:0] r, sg, rh, rl,
                         input logic us, input logic uk);
        logic [1:0] sk;
        @(negedge clk);
        md4 = md; req4 = r; sg4 = sg; rh4 = rh; rl4 = rl; us4 = us; uk4 = uk;
        sk = ref_fn(md, r, sg, rh, rl, us, uk);
        #1;
        chk("R8", "set_o", s4, sk[1]);
        chk("R8", "keep_o", k4, sk[0]);
        @(posedge clk); #1;
        m4 = sk[1] | (m4 & sk[0]);
        chk(tag, "c_o", c4, m4);
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        rst = 1'b1; md4 = 1'b0; req4 = 4'hF; us4 = 1'b1; uk4 = 1'b0;
        a12 = 2'b11; a3 = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "main c_o under reset", c4, 1'b0);
        chk("R1", "c2 c_o under reset", c2, 1'b0);
        chk("R1", "c1 c_o under reset", c1, 1'b0);
        chk("R1", "c3 c_o under reset", c3, 1'b0);
        @(negedge clk);
        rst = 1'b0; req4 = 4'h0; a12 = 2'b00; a3 = 1'b0;
        m4 = 1'b0; mc2 = 1'b0; mc3 = 1'b0;
        step4("R2", 1'b0, 4'hF, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0);
        step4("R2", 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0);
    endtask

    task automatic t_sym_r3();
        // masks carry junk to show they are ignored (R7)
        step4("R3", 1'b0, 4'h7, 4'hA, 4'h5, 4'h3, 1'b1, 1'b0);
        step4("R3", 1'b0, 4'hF, 4'h6, 4'h9, 4'hC, 1'b1, 1'b0);
        step4("R3", 1'b0, 4'h8, 4'hF, 4'h0, 4'hF, 1'b1, 1'b0);
        step4("R3", 1'b0, 4'h1, 4'h3, 4'h3, 4'h0, 1'b1, 1'b0);
        step4("R3", 1'b0, 4'h0, 4'h5, 4'hA, 4'h1, 1'b1, 1'b0);
        step4("R3", 1'b0, 4'hE, 4'h0, 4'hF, 4'hF, 1'b1, 1'b0);
        step4("R7", 1'b0, 4'hF, 4'h1, 4'h0, 4'h0, 1'b1, 1'b0);
        step4("R7", 1'b0, 4'h0, 4'h1, 4'h0, 4'h0, 1'b1, 1'b0);
    endtask

    task automatic t_up_r8();
        step4("R8", 1'b0, 4'hF, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0); // blocked set
        step4("R8", 1'b0, 4'hF, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0);
        step4("R8", 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b1); // forced hold
        step4("R8", 1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0);
    endtask

    task automatic t_asym_r10();
        // a = bit0, b = bit1, c = bit2: set = bc, reset = ab'
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 16; v++) begin
                step4("R10", 1'b1, 4'(v), 4'b0110, 4'b0001, 4'b0010, 1'b1, 1'b0);
            end
        end
        step4("R10", 1'b1, 4'b0110, 4'b0110, 4'b0001, 4'b0010, 1'b1, 1'b0);
        step4("R10", 1'b1, 4'b0101, 4'b0110, 4'b0001, 4'b0010, 1'b1, 1'b0);
    endtask

    task automatic t_groups_r5_r6();
        // set on bits 0 and 3, reset on bit1 high with bit0 low
        step4("R5", 1'b1, 4'b1001, 4'b1001, 4'b0010, 4'b0001, 1'b1, 1'b0);
        step4("R6", 1'b1, 4'b0010, 4'b1001, 4'b0010, 4'b0001, 1'b1, 1'b0);
        step4("R5", 1'b1, 4'b0001, 4'b1001, 4'b0010, 4'b0001, 1'b1, 1'b0);
        // empty set group never sets
        step4("R5", 1'b1, 4'hF, 4'b0000, 4'b0000, 4'b0100, 1'b1, 1'b0);
        step4("R5", 1'b1, 4'hB, 4'b0000, 4'b0000, 4'b0100, 1'b1, 1'b0);
        // empty reset masks never reset
        step4("R6", 1'b1, 4'b0011, 4'b0011, 4'b0000, 4'b0000, 1'b1, 1'b0);
        step4("R6", 1'b1, 4'b0000, 4'b0011, 4'b0000, 4'b0000, 1'b1, 1'b0);
        step4("R6", 1'b1, 4'b1100, 4'b0011, 4'b0000, 4'b0000, 1'b1, 1'b0);
        step4("R6", 1'b1, 4'b0000, 4'b0011, 4'b0000, 4'b0011, 1'b1, 1'b0);
    endtask

    task automatic t_maj_r4();
        logic [1:0] seq [0:10];
        seq = '{2'b00, 2'b01, 2'b11, 2'b10, 2'b00, 2'b10, 2'b11, 2'b01, 2'b00, 2'b11, 2'b00};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            a12 = seq[i];
            @(posedge clk); #1;
            mc2 = (a12[0] & a12[1]) | (a12[1] & mc2) | (a12[0] & mc2);
            chk("R4", "2-input c_o", c2, mc2);
        end
    endtask

    task automatic t_cascade_r9();
        for (int i = 0; i < 300; i++) begin
            logic [2:0] v;
            @(negedge clk);
            v = 3'($urandom);
            a12 = v[1:0]; a3 = v[2];
            @(posedge clk); #1;
            mc3 = (&v) | (mc3 & (|v));
            chk("R9", "cascade vs 3-input", c1, c3);
            chk("R9", "cascade vs model", c1, mc3);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "main c_o after power-up reset", c4, 1'b0);
        chk("R1", "c3 c_o after power-up reset", c3, 1'b0);
        t_reset_r1();
        t_sym_r3();
        t_up_r8();
        t_asym_r10();
        t_groups_r5_r6();
        t_maj_r4();
        t_cascade_r9();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule